// File: doc/BRIEF.md
# Vector Length Configuration Unit

This block holds the configuration state of a scalable vector engine. The state has two parts: the type (element width, register-group multiplier and an illegal flag) and the active element count. A configuration request carries three things: a requested application vector length, a 6-bit type immediate, and two flags that say whether the length source register and the scalar destination register are the zero register.

In one clock edge the unit does the following:
- It decodes the immediate.
- It rejects type combinations the engine cannot hold.
- It works out the largest element count that fits the register group.
- It commits the new type and count together.
- It returns the granted count so that it can be written to the scalar destination.

The register width in bits (VLEN) and the widest supported element (ELEN) are elaboration parameters. Both are powers of two. Every quantity in the maximum-count computation is a power of two, so that computation is a pure exponent sum with no multiplier or divider.

Top module: `vcfg_unit`

## Requirements
- R1: After reset the unit reports an illegal type (`cfg_illegal` = 1), element width code 0, group code 0, `cfg_vl` = 0 and `rsp_valid` = 0.
- R2: The immediate `req_vtypei` carries the group code in bits [2:0] and the width code in bits [5:3]. The width code c selects SEW = 8·2^c. The group codes are 000→1, 001→2, 010→4, 011→8, 101→1/8, 110→1/4, 111→1/2. A legal request shows both codes on `cfg_sew` and `cfg_lmul`.
- R3: For a legal type the maximum count is VLMAX = (VLEN / SEW) · LMUL.
- R4: With an explicit length source, the granted count is min(AVL, VLMAX). AVL is treated as an unsigned number.
- R5: When the length source is the zero register and the destination is not, the granted count equals VLMAX.
- R6: When both the length source and the destination are the zero register and the type is legal, the count keeps its previous value and the type still updates.
- R7: Group code 100 is reserved. A request that uses it sets `cfg_illegal`, clears both codes and forces the count to 0.
- R8: A request with SEW > ELEN is illegal and behaves as in R7.
- R9: A fractional group with SEW > LMUL·ELEN is illegal and behaves as in R7.
- R10: A request with `req_valid` high updates the type and the count at the same clock edge. In the cycle after that edge, `rsp_valid` is high and `rsp_vl` equals the new `cfg_vl`. Requests may arrive back to back.
- R11: While `req_valid` is low, the type, the count and `rsp_valid` = 0 hold unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Configuration request strobe |
| req_avl | input | XLEN | Requested application vector length |
| req_avl_is_x0 | input | 1 | Length source register is the zero register |
| req_rd_is_x0 | input | 1 | Scalar destination is the zero register |
| req_vtypei | input | 6 | Type immediate: [5:3] width code, [2:0] group code |
| rsp_valid | output | 1 | Granted length is valid this cycle |
| rsp_vl | output | XLEN | Granted length for the scalar destination |
| cfg_sew | output | 3 | Committed width code |
| cfg_lmul | output | 3 | Committed group code |
| cfg_illegal | output | 1 | Committed type is illegal |
| cfg_vl | output | XLEN | Committed active element count |

## Verification
The bench builds the unit with VLEN = 128, ELEN = 32 and XLEN = 32. With an ELEN below the 64-bit width code, the SEW > ELEN rejection can be reached. The narrow ELEN also makes the fractional-group rule bite on several legal-looking pairs: 1/8 with 8-bit elements and 1/2 with 32-bit elements are rejected, while 1/4 with 8-bit elements is accepted and gives a count of 4. The largest count, 128 at 8-bit elements and group 8, fits exactly in the 8-bit internal maximum path, so the clamp is exercised at the top of its range as well as at the 16 = VLMAX boundary.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;

  localparam int unsigned CODE_W = 3;
  localparam int unsigned VTYPEI_W = 2 * CODE_W;
  localparam logic [CODE_W-1:0] LMUL_RSVD = 3'b100;

  // Signed exponent of the group multiplier: codes 5..7 are fractional.
  function automatic int grp_exp(input logic [CODE_W-1:0] lmul);
    return lmul[2] ? (int'(lmul) - 8) : int'(lmul);
  endfunction

  // log2(SEW) for a width code (SEW = 8 << code).
  function automatic int sew_exp(input logic [CODE_W-1:0] sew);
    return 3 + int'(sew);
  endfunction

  // Legality of a type against log2(ELEN).
  function automatic logic type_bad(input logic [CODE_W-1:0] sew,
                                    input logic [CODE_W-1:0] lmul,
                                    input int elen_log2);
    int k;
    k = grp_exp(lmul);
    if (lmul == LMUL_RSVD) return 1'b1;
    if (sew_exp(sew) > elen_log2) return 1'b1;
    if (k < 0 && sew_exp(sew) > elen_log2 + k) return 1'b1;
    return 1'b0;
  endfunction

  // log2(VLMAX) = log2(VLEN) - log2(SEW) + k; a negative exponent means zero elements.
  function automatic logic [31:0] max_elems(input logic [CODE_W-1:0] sew,
                                            input logic [CODE_W-1:0] lmul,
                                            input int vlen_log2);
    int e;
    e = vlen_log2 - sew_exp(sew) + grp_exp(lmul);
    if (e < 0) return 32'd0;
    return 32'd1 << e;
  endfunction

endpackage

// File: rtl/vcfg_decode.sv
module vcfg_decode
  import vcfg_pkg::*;
#(
  parameter int unsigned ELEN = 64
) (
  input  logic [VTYPEI_W-1:0] vtypei,
  output logic [CODE_W-1:0]   sew,
  output logic [CODE_W-1:0]   lmul,
  output logic                illegal
);
  localparam int ELEN_LOG2 = $clog2(ELEN);

  assign lmul    = vtypei[CODE_W-1:0];
  assign sew     = vtypei[VTYPEI_W-1:CODE_W];
  assign illegal = type_bad(sew, lmul, ELEN_LOG2);
endmodule

// File: rtl/vcfg_vlmax.sv
module vcfg_vlmax
  import vcfg_pkg::*;
#(
  parameter int unsigned VLEN = 128,
  parameter int unsigned VW   = $clog2(VLEN) + 1
) (
  input  logic [CODE_W-1:0] sew,
  input  logic [CODE_W-1:0] lmul,
  output logic [VW-1:0]     vlmax
);
  localparam int VLEN_LOG2 = $clog2(VLEN);
  logic [31:0] full;

  assign full  = max_elems(sew, lmul, VLEN_LOG2);
  assign vlmax = full[VW-1:0];
endmodule

// File: rtl/vcfg_grant.sv
module vcfg_grant #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned VW   = 9
) (
  input  logic [XLEN-1:0] avl,
  input  logic            avl_x0,
  input  logic            rd_x0,
  input  logic            illegal,
  input  logic [VW-1:0]   vlmax,
  input  logic [XLEN-1:0] cur_vl,
  output logic [XLEN-1:0] next_vl
);
  logic [XLEN-1:0] vlmax_x;

  assign vlmax_x = XLEN'(vlmax);

  always_comb begin
    if (illegal)
      next_vl = '0;
    else if (avl_x0 && rd_x0)
      next_vl = cur_vl;
    else if (avl_x0)
      next_vl = vlmax_x;
    else if (avl < vlmax_x)
      next_vl = avl;
    else
      next_vl = vlmax_x;
  end
endmodule

// File: rtl/vcfg_unit.sv
module vcfg_unit
  import vcfg_pkg::*;
#(
  parameter int unsigned VLEN = 128,
  parameter int unsigned ELEN = 64,
  parameter int unsigned XLEN = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [XLEN-1:0]     req_avl,
  input  logic                req_avl_is_x0,
  input  logic                req_rd_is_x0,
  input  logic [VTYPEI_W-1:0] req_vtypei,
  output logic                rsp_valid,
  output logic [XLEN-1:0]     rsp_vl,
  output logic [CODE_W-1:0]   cfg_sew,
  output logic [CODE_W-1:0]   cfg_lmul,
  output logic                cfg_illegal,
  output logic [XLEN-1:0]     cfg_vl
);
  localparam int unsigned VW = $clog2(VLEN) + 1;

  // Named internal events, visible to the checker.
  logic [CODE_W-1:0] dec_sew;
  logic [CODE_W-1:0] dec_lmul;
  logic              dec_illegal;
  logic [VW-1:0]     vlmax_val;
  logic [XLEN-1:0]   grant_vl;

  vcfg_decode #(.ELEN(ELEN)) u_decode (
    .vtypei (req_vtypei),
    .sew    (dec_sew),
    .lmul   (dec_lmul),
    .illegal(dec_illegal)
  );

  vcfg_vlmax #(.VLEN(VLEN), .VW(VW)) u_vlmax (
    .sew  (dec_sew),
    .lmul (dec_lmul),
    .vlmax(vlmax_val)
  );

  vcfg_grant #(.XLEN(XLEN), .VW(VW)) u_grant (
    .avl    (req_avl),
    .avl_x0 (req_avl_is_x0),
    .rd_x0  (req_rd_is_x0),
    .illegal(dec_illegal),
    .vlmax  (vlmax_val),
    .cur_vl (cfg_vl),
    .next_vl(grant_vl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_sew     <= '0;
      cfg_lmul    <= '0;
      cfg_illegal <= 1'b1;
      cfg_vl      <= '0;
      rsp_valid   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        cfg_illegal <= dec_illegal;
        cfg_sew     <= dec_illegal ? '0 : dec_sew;
        cfg_lmul    <= dec_illegal ? '0 : dec_lmul;
        cfg_vl      <= grant_vl;
      end
    end
  end

  assign rsp_vl = cfg_vl;
endmodule

// File: rtl/vcfg_unit_chk.sv
module vcfg_unit_chk #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned VW   = 9
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_avl_is_x0,
  input logic            req_rd_is_x0,
  input logic            dec_illegal,
  input logic [VW-1:0]   vlmax_val,
  input logic            rsp_valid,
  input logic [XLEN-1:0] rsp_vl,
  input logic [XLEN-1:0] cfg_vl,
  input logic            cfg_illegal,
  input logic [2:0]      cfg_sew,
  input logic [2:0]      cfg_lmul
);
  // R7
  illegal_zero_vl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_illegal |-> (cfg_vl == '0 && cfg_sew == '0 && cfg_lmul == '0));

  // R8
  bad_req_commits_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && dec_illegal) |=> (cfg_illegal && cfg_vl == '0));

  // R4
  vl_within_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !dec_illegal && !(req_avl_is_x0 && req_rd_is_x0))
      |=> (cfg_vl <= XLEN'($past(vlmax_val))));

  // R5
  x0_avl_gives_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !dec_illegal && req_avl_is_x0 && !req_rd_is_x0)
      |=> (cfg_vl == XLEN'($past(vlmax_val))));

  // R6
  keep_vl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !dec_illegal && req_avl_is_x0 && req_rd_is_x0) |=> $stable(cfg_vl));

  // R10
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_valid && rsp_vl == cfg_vl));

  // R11
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && $stable(cfg_vl) && $stable(cfg_illegal)
                    && $stable(cfg_sew) && $stable(cfg_lmul)));
endmodule

bind vcfg_unit vcfg_unit_chk #(.XLEN(XLEN), .VW(VW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_avl_is_x0(req_avl_is_x0),
  .req_rd_is_x0 (req_rd_is_x0),
  .dec_illegal  (dec_illegal),
  .vlmax_val    (vlmax_val),
  .rsp_valid    (rsp_valid),
  .rsp_vl       (rsp_vl),
  .cfg_vl       (cfg_vl),
  .cfg_illegal  (cfg_illegal),
  .cfg_sew      (cfg_sew),
  .cfg_lmul     (cfg_lmul)
);

// File: tb/vcfg_unit_bench.sv
`timescale 1ns/1ps
module vcfg_unit_bench;
  localparam int unsigned VLEN = 128;
  localparam int unsigned ELEN = 32;
  localparam int unsigned XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic [XLEN-1:0] req_avl = '0;
  logic            req_avl_is_x0 = 1'b0;
  logic            req_rd_is_x0 = 1'b0;
  logic [5:0]      req_vtypei = '0;
  logic            rsp_valid;
  logic [XLEN-1:0] rsp_vl;
  logic [2:0]      cfg_sew;
  logic [2:0]      cfg_lmul;
  logic            cfg_illegal;
  logic [XLEN-1:0] cfg_vl;

  always #2 clk = ~clk;

  vcfg_unit #(.VLEN(VLEN), .ELEN(ELEN), .XLEN(XLEN)) u_vcfg_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_avl(req_avl),
    .req_avl_is_x0(req_avl_is_x0), .req_rd_is_x0(req_rd_is_x0),
    .req_vtypei(req_vtypei), .rsp_valid(rsp_valid), .rsp_vl(rsp_vl),
    .cfg_sew(cfg_sew), .cfg_lmul(cfg_lmul), .cfg_illegal(cfg_illegal),
    .cfg_vl(cfg_vl)
  );

  typedef struct {
    longint vl;
    bit     ill;
    int     sew;
    int     lmul;
    string  tag;
  } exp_t;

  exp_t   sb[$];
  int     n_chk = 0;
  int     n_bad = 0;
  longint m_vl = 0;
  bit     m_ill = 1'b1;
  int     m_sew = 0;
  int     m_lmul = 0;

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model written with multiplication and division.
  task automatic req(input string tag, input longint avl, input bit ax0, input bit rx0,
                     input int sew_c, input int lmul_c);
    int sew_bits;
    int num;
    int den;
    bit bad;
    longint vmax;
    exp_t e;
    sew_bits = 8 * (1 << sew_c);
    num = 1;
    den = 1;
    if (lmul_c <= 3) num = 1 << lmul_c;
    else if (lmul_c >= 5) den = 1 << (8 - lmul_c);
    bad = (lmul_c == 4) || (sew_bits > ELEN) || (den > 1 && sew_bits * den > ELEN);
    vmax = (VLEN * num) / (sew_bits * den);
    if (bad) m_vl = 0;
    else if (ax0 && rx0) m_vl = m_vl;
    else if (ax0) m_vl = vmax;
    else m_vl = (avl < vmax) ? avl : vmax;
    m_ill = bad;
    m_sew = bad ? 0 : sew_c;
    m_lmul = bad ? 0 : lmul_c;
    e.vl = m_vl; e.ill = m_ill; e.sew = m_sew; e.lmul = m_lmul; e.tag = tag;
    @(negedge clk);
    req_valid = 1'b1;
    req_avl = XLEN'(avl);
    req_avl_is_x0 = ax0;
    req_rd_is_x0 = rx0;
    req_vtypei = {3'(sew_c), 3'(lmul_c)};
    sb.push_back(e);
  endtask

  // Idle cycles: state must hold (R11) and no response appears.
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      req_avl = 32'hDEAD_BEEF;
      req_vtypei = 6'b111_100;
      check("R11 hold vl", cfg_vl, m_vl);
      check("R11 hold illegal", cfg_illegal, m_ill);
      if (i > 0) check("R11 no rsp", rsp_valid, 0);
    end
  endtask

  // Monitor: pops one expected item per response.
  always @(posedge clk) begin
    #1;
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        check("R10 unexpected rsp", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " rsp_vl"}, rsp_vl, e.vl);
        check({e.tag, " R10 cfg_vl"}, cfg_vl, e.vl);
        check({e.tag, " illegal"}, cfg_illegal, e.ill);
        check({e.tag, " R2 sew"}, cfg_sew, e.sew);
        check({e.tag, " R2 lmul"}, cfg_lmul, e.lmul);
      end
    end
  end

  initial begin
    #(200000 * 4);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #9;
    check("R1 reset illegal", cfg_illegal, 1);
    check("R1 reset vl", cfg_vl, 0);
    check("R1 reset rsp_valid", rsp_valid, 0);
    check("R1 reset sew", cfg_sew, 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    req("R4 e8 m1 short", 5, 0, 0, 0, 0);
    req("R4 e8 m1 clamp", 100, 0, 0, 0, 0);
    req("R3 e16 m2 at max", 16, 0, 0, 1, 1);
    req("R3 e16 m2 above max", 17, 0, 0, 1, 1);
    req("R3 e32 m8", 1000, 0, 0, 2, 3);
    req("R4 avl zero", 0, 0, 0, 0, 2);
    req("R4 avl huge unsigned", 64'hFFFF_FFFF, 0, 0, 0, 1);
    idle(3);
    req("R5 x0 avl e8 m8", 3, 1, 0, 0, 3);
    req("R9 e8 mf4 legal", 9, 0, 0, 0, 6);
    req("R6 keep vl e16 m1", 77, 1, 1, 1, 0);
    idle(2);
    req("R7 reserved lmul", 10, 0, 0, 0, 4);
    req("R8 e64 over elen", 10, 0, 0, 3, 0);
    req("R8 e1024", 10, 1, 0, 7, 0);
    req("R5 recover e32 m1", 2, 1, 0, 2, 0);
    req("R9 e8 mf8 illegal", 10, 0, 0, 0, 5);
    req("R9 e32 mf2 illegal", 10, 0, 0, 2, 7);
    req("R9 e16 mf2 legal", 50, 0, 0, 1, 7);
    req("R6 keep vl e8 m2", 1, 1, 1, 0, 1);
    req("R7 keep x0 illegal", 1, 1, 1, 0, 4);
    idle(3);
    check("R10 scoreboard drained", sb.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule